// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small accumulator machine whose datapath holds a program counter, a memory address register, a memory buffer register, an instruction register (opcode, indirect flag, address field), a working register R1 and an accumulator. A control store of horizontal microwords drives the datapath. Each word carries one enable bit per datapath transfer, a condition selector, a next-address kind and a branch target. A control address register walks the store, and a registered control buffer presents one complete control vector per clock.

Sequencing has four kinds of next address. The first steps to the next word. The second jumps inside the current routine when the selected condition is true. The third dispatches through the opcode decoder to the start of a machine-instruction routine. The fourth returns to the fetch routine. A branch target is taken only when its condition holds. The store holds a fetch routine, an indirect-address routine, an interrupt-save routine and execute routines for a register-memory add and a register-memory AND. The two execute routines share a common write-back tail.

The opcode and indirect flag inputs carry the value the instruction register will hold after the current clock edge. This lets the last fetch word dispatch in the same cycle that loads the instruction register.

Top module: `useq_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `car_o` is 0, the start of the fetch routine. `ctl_o` is all zeros while reset is asserted. At the first clock edge after release, the word at address 0 is presented.
- R2: Fetch occupies addresses 0, 1 and 2 in consecutive cycles. The control vectors are: bit 0 (MAR from PC); then bits 3, 6 and 10 (MBR from memory, PC increment, bus read); then bit 8 (IR from MBR).
- R3: After fetch word 2, control goes to address 3 when `ind_d` is 1. Otherwise it goes to the opcode routine start selected by `op_d`.
- R4: The indirect routine occupies addresses 3, 4 and 5 with vectors bit 1 (MAR from IR address), then bits 3 and 10, then bit 9 (IR address field from MBR address field). It then dispatches on `op_d` without testing the indirect flag.
- R5: The opcode decoder maps opcode 1 to address 9 and opcode 2 to address 12. Every other opcode maps to address 0, so an undefined instruction goes straight back to fetch.
- R6: The add routine is address 9 (bit 1), address 10 (bits 3 and 10), address 11 (bit 12, accumulator takes R1 plus MBR), then address 15 (bit 14, R1 takes the accumulator).
- R7: The AND routine is address 12 (bit 1), address 13 (bits 3 and 10), address 14 (bit 13, accumulator takes R1 AND MBR), then address 15 (bit 14).
- R8: After the word at address 15, control goes to address 6 if `irq_pend` is 1 and to address 0 otherwise. `irq_pend` has no effect on any fetch, indirect or execute step before that word.
- R9: The interrupt routine occupies addresses 6, 7 and 8 with vectors bit 4 (MBR from PC), then bits 2 and 7 (MAR from save address, PC from handler address), then bits 5 and 11 (memory from MBR, bus write). It then returns to address 0 even while `irq_pend` stays high.
- R10: No cycle asserts both bus read (bit 10) and bus write (bit 11). At most one of bits 0, 1 and 2 (MAR sources) is set in any cycle, and bits 3 and 4 (MBR sources) are never both set.
- R11: `car_o` always gives the store address of the word whose control vector is on `ctl_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_d | input | OPW | Opcode field of the instruction register's next-state value |
| ind_d | input | 1 | Indirect flag of the instruction register's next-state value |
| irq_pend | input | 1 | Interrupt request pending, synchronous to clk |
| ctl_o | output | 15 | Horizontal control vector of the current microword |
| car_o | output | 5 | Control store address of the current microword |

## Verification
The properties assume that `op_d` and `ind_d` reflect what the instruction register will hold after the coming edge. They also assume that `irq_pend` is synchronous and stable around each rising edge. Without these, the dispatch and return checks would compare against a stale instruction. The bench guarantees both by deriving `op_d` and `ind_d` combinationally from its own datapath model, which is driven by `ctl_o`. It changes `irq_pend` only at falling edges. It raises `irq_pend` across whole fetch and execute sequences to show that only the write-back word samples it.

// File: rtl/useq_pkg.sv
package useq_pkg;

   // control vector width and store address width
   localparam int CTL_W = 15;
   localparam int UA_W  = 5;

   // control signal bit positions
   localparam int S_MAR_PC   = 0;
   localparam int S_MAR_IRA  = 1;
   localparam int S_MAR_SAVE = 2;
   localparam int S_MBR_MEM  = 3;
   localparam int S_MBR_PC   = 4;
   localparam int S_MEM_MBR  = 5;
   localparam int S_PC_INC   = 6;
   localparam int S_PC_HDL   = 7;
   localparam int S_IR_MBR   = 8;
   localparam int S_IRA_MBRA = 9;
   localparam int S_BUS_RD   = 10;
   localparam int S_BUS_WR   = 11;
   localparam int S_ACC_ADD  = 12;
   localparam int S_ACC_AND  = 13;
   localparam int S_R1_ACC   = 14;

   // next-address kind
   typedef enum logic [1:0] {
      NX_SEQ  = 2'd0,   // step by one
      NX_JMP  = 2'd1,   // target if condition, else step
      NX_DISP = 2'd2,   // target if condition, else opcode routine
      NX_RET  = 2'd3    // target if condition, else fetch
   } nx_e;

   // condition selector
   typedef enum logic [1:0] {
      CD_ALWAYS = 2'd0,
      CD_IND    = 2'd1,
      CD_IRQ    = 2'd2,
      CD_NEVER  = 2'd3
   } cd_e;

   typedef struct packed {
      logic [CTL_W-1:0] sig;
      nx_e              nx;
      cd_e              cd;
      logic [UA_W-1:0]  tgt;
   } uword_t;

   // routine entry points
   localparam logic [UA_W-1:0] UA_FETCH = UA_W'(0);
   localparam logic [UA_W-1:0] UA_INDIR = UA_W'(3);
   localparam logic [UA_W-1:0] UA_INTR  = UA_W'(6);
   localparam logic [UA_W-1:0] UA_ADD   = UA_W'(9);
   localparam logic [UA_W-1:0] UA_AND   = UA_W'(12);
   localparam logic [UA_W-1:0] UA_TAIL  = UA_W'(15);

   // word held in the buffer during reset: no signals, return to fetch
   localparam uword_t BUBBLE = '{sig: '0, nx: NX_RET, cd: CD_NEVER, tgt: UA_FETCH};

endpackage

// File: rtl/useq_rom.sv
module useq_rom
   import useq_pkg::*;
(
   input  logic [UA_W-1:0] addr,
   output uword_t          word
);

   function automatic logic [CTL_W-1:0] b(input int i);
      return CTL_W'(1) << i;
   endfunction

   function automatic uword_t mk(input logic [CTL_W-1:0] s, input nx_e n,
                                 input cd_e c, input logic [UA_W-1:0] t);
      return '{sig: s, nx: n, cd: c, tgt: t};
   endfunction

   always_comb begin
      case (addr)
         // fetch
         UA_FETCH:          word = mk(b(S_MAR_PC), NX_SEQ, CD_NEVER, UA_FETCH);
         UA_FETCH+UA_W'(1): word = mk(b(S_MBR_MEM) | b(S_BUS_RD) | b(S_PC_INC),
                                      NX_SEQ, CD_NEVER, UA_FETCH);
         UA_FETCH+UA_W'(2): word = mk(b(S_IR_MBR), NX_DISP, CD_IND, UA_INDIR);
         // indirect
         UA_INDIR:          word = mk(b(S_MAR_IRA), NX_SEQ, CD_NEVER, UA_FETCH);
         UA_INDIR+UA_W'(1): word = mk(b(S_MBR_MEM) | b(S_BUS_RD), NX_SEQ, CD_NEVER, UA_FETCH);
         UA_INDIR+UA_W'(2): word = mk(b(S_IRA_MBRA), NX_DISP, CD_NEVER, UA_FETCH);
         // interrupt save
         UA_INTR:           word = mk(b(S_MBR_PC), NX_SEQ, CD_NEVER, UA_FETCH);
         UA_INTR+UA_W'(1):  word = mk(b(S_MAR_SAVE) | b(S_PC_HDL), NX_SEQ, CD_NEVER, UA_FETCH);
         UA_INTR+UA_W'(2):  word = mk(b(S_MEM_MBR) | b(S_BUS_WR), NX_RET, CD_NEVER, UA_FETCH);
         // add
         UA_ADD:            word = mk(b(S_MAR_IRA), NX_SEQ, CD_NEVER, UA_FETCH);
         UA_ADD+UA_W'(1):   word = mk(b(S_MBR_MEM) | b(S_BUS_RD), NX_SEQ, CD_NEVER, UA_FETCH);
         UA_ADD+UA_W'(2):   word = mk(b(S_ACC_ADD), NX_JMP, CD_ALWAYS, UA_TAIL);
         // and, falls through into the shared tail
         UA_AND:            word = mk(b(S_MAR_IRA), NX_SEQ, CD_NEVER, UA_FETCH);
         UA_AND+UA_W'(1):   word = mk(b(S_MBR_MEM) | b(S_BUS_RD), NX_SEQ, CD_NEVER, UA_FETCH);
         UA_AND+UA_W'(2):   word = mk(b(S_ACC_AND), NX_SEQ, CD_NEVER, UA_FETCH);
         // shared write-back tail
         UA_TAIL:           word = mk(b(S_R1_ACC), NX_RET, CD_IRQ, UA_INTR);
         default:           word = BUBBLE;
      endcase
   end

endmodule

// File: rtl/useq_opdec.sv
module useq_opdec
   import useq_pkg::*;
#(
   parameter int OPW    = 4,
   parameter int OP_ADD = 1,
   parameter int OP_AND = 2
) (
   input  logic [OPW-1:0]  opcode,
   output logic [UA_W-1:0] start
);

   always_comb begin
      if (opcode == OPW'(OP_ADD))      start = UA_ADD;
      else if (opcode == OPW'(OP_AND)) start = UA_AND;
      else                             start = UA_FETCH;
   end

endmodule

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
   import useq_pkg::*;
(
   input  logic [UA_W-1:0] car,
   input  uword_t          cur,
   input  logic [UA_W-1:0] map,
   input  logic            ind,
   input  logic            irq,
   output logic [UA_W-1:0] nxt
);

   logic            hit;
   logic [UA_W-1:0] inc;

   always_comb begin
      case (cur.cd)
         CD_ALWAYS: hit = 1'b1;
         CD_IND:    hit = ind;
         CD_IRQ:    hit = irq;
         default:   hit = 1'b0;
      endcase
      inc = car + UA_W'(1);
      case (cur.nx)
         NX_SEQ:  nxt = inc;
         NX_JMP:  nxt = hit ? cur.tgt : inc;
         NX_DISP: nxt = hit ? cur.tgt : map;
         default: nxt = hit ? cur.tgt : UA_FETCH;
      endcase
   end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
   import useq_pkg::*;
#(
   parameter int OPW    = 4,
   parameter int OP_ADD = 1,
   parameter int OP_AND = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPW-1:0]   op_d,
   input  logic             ind_d,
   input  logic             irq_pend,
   output logic [CTL_W-1:0] ctl_o,
   output logic [UA_W-1:0]  car_o
);

   localparam int OP_SPAN = 1 << OPW;

   generate
      if (OPW < 2 || OPW > 8) begin : g_bad_opw
         $error("useq_ctrl: OPW out of range");
      end
      if (OP_ADD == OP_AND) begin : g_bad_ops
         $error("useq_ctrl: opcodes must differ");
      end
      if (OP_ADD >= OP_SPAN || OP_AND >= OP_SPAN) begin : g_bad_span
         $error("useq_ctrl: opcode does not fit OPW");
      end
   endgenerate

   logic [UA_W-1:0] car_q;
   uword_t          cbr_q;
   logic [UA_W-1:0] map_a;
   logic [UA_W-1:0] nxt_a;
   uword_t          rom_w;

   useq_opdec #(.OPW(OPW), .OP_ADD(OP_ADD), .OP_AND(OP_AND)) u_dec (
      .opcode (op_d),
      .start  (map_a)
   );

   useq_nextaddr u_nxt (
      .car (car_q),
      .cur (cbr_q),
      .map (map_a),
      .ind (ind_d),
      .irq (irq_pend),
      .nxt (nxt_a)
   );

   useq_rom u_rom (
      .addr (nxt_a),
      .word (rom_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         car_q <= UA_FETCH;
         cbr_q <= BUBBLE;
      end else begin
         car_q <= nxt_a;
         cbr_q <= rom_w;
      end
   end

   assign ctl_o = cbr_q.sig;
   assign car_o = car_q;

endmodule

// File: rtl/useq_chk.sv
module useq_chk
   import useq_pkg::*;
#(
   parameter int OPW    = 4,
   parameter int OP_ADD = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [OPW-1:0]   op_d,
   input logic             ind_d,
   input logic             irq_pend,
   input logic [CTL_W-1:0] ctl_o,
   input logic [UA_W-1:0]  car_o
);

   localparam logic [UA_W-1:0] A_F1 = UA_FETCH + UA_W'(1);
   localparam logic [UA_W-1:0] A_F2 = UA_FETCH + UA_W'(2);

   assert_fetch_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (car_o == UA_FETCH && ctl_o[S_MAR_PC])
      |=> (car_o == A_F1 && ctl_o[S_BUS_RD] && ctl_o[S_PC_INC] && ctl_o[S_MBR_MEM]));

   assert_to_indirect_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (car_o == A_F2 && ind_d) |=> (car_o == UA_INDIR && ctl_o[S_MAR_IRA]));

   assert_map_add_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (car_o == A_F2 && !ind_d && op_d == OPW'(OP_ADD)) |=> (car_o == UA_ADD));

   assert_end_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_o[S_R1_ACC] && irq_pend) |=> (car_o == UA_INTR && ctl_o[S_MBR_PC]));

   assert_end_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_o[S_R1_ACC] && !irq_pend) |=> (car_o == UA_FETCH && ctl_o[S_MAR_PC]));

   assert_intr_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_o[S_BUS_WR] |=> (car_o == UA_FETCH));

   assert_bus_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctl_o[S_BUS_RD] && ctl_o[S_BUS_WR]));

   assert_mar_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctl_o[S_MAR_SAVE], ctl_o[S_MAR_IRA], ctl_o[S_MAR_PC]}));

   assert_mbr_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctl_o[S_MBR_PC], ctl_o[S_MBR_MEM]}));

endmodule

bind useq_ctrl useq_chk #(.OPW(OPW), .OP_ADD(OP_ADD)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_d     (op_d),
   .ind_d    (ind_d),
   .irq_pend (irq_pend),
   .ctl_o    (ctl_o),
   .car_o    (car_o)
);

// File: tb/tb_useq_ctrl.sv
module tb_useq_ctrl;

   // expected control vectors, from the bit positions in the requirements
   localparam logic [14:0] V_F0   = 15'h0001;
   localparam logic [14:0] V_F1   = 15'h0448;
   localparam logic [14:0] V_F2   = 15'h0100;
   localparam logic [14:0] V_MARI = 15'h0002;
   localparam logic [14:0] V_RD   = 15'h0408;
   localparam logic [14:0] V_I2   = 15'h0200;
   localparam logic [14:0] V_Q0   = 15'h0010;
   localparam logic [14:0] V_Q1   = 15'h0084;
   localparam logic [14:0] V_Q2   = 15'h0820;
   localparam logic [14:0] V_ADD  = 15'h1000;
   localparam logic [14:0] V_AND  = 15'h2000;
   localparam logic [14:0] V_TAIL = 15'h4000;
   localparam logic [7:0]  SAVE_A = 8'hF0;
   localparam logic [10:0] HDL_A  = 11'h080;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        irq_pend = 1'b0;
   logic [3:0]  op_d;
   logic        ind_d;
   logic [14:0] ctl;
   logic [4:0]  car;

   useq_ctrl dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_d     (op_d),
      .ind_d    (ind_d),
      .irq_pend (irq_pend),
      .ctl_o    (ctl),
      .car_o    (car)
   );

   // datapath model driven by the control vector
   logic [10:0] pc, mar;
   logic [15:0] mbr, ir, ac, r1, ir_nx;
   logic [15:0] mem [0:255];

   always_comb begin
      if (ctl[8])      ir_nx = mbr;
      else if (ctl[9]) ir_nx = {ir[15:11], mbr[10:0]};
      else             ir_nx = ir;
   end
   assign op_d  = ir_nx[15:12];
   assign ind_d = ir_nx[11];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= 16'h0000;
         mem[8'h00] <= 16'h1020;   // add direct 0x20
         mem[8'h01] <= 16'h2821;   // and indirect via 0x21
         mem[8'h02] <= 16'h7040;   // undefined opcode
         mem[8'h03] <= 16'h1020;   // add direct 0x20
         mem[8'h20] <= 16'h0005;
         mem[8'h21] <= 16'h0030;
         mem[8'h30] <= 16'h0003;
         mem[8'h31] <= 16'h0004;
         mem[8'h80] <= 16'h2031;   // handler: and direct 0x31
         pc <= '0; mar <= '0; mbr <= '0; ir <= '0; ac <= '0; r1 <= 16'd3;
      end else begin
         if (ctl[0]) mar <= pc;
         if (ctl[1]) mar <= ir[10:0];
         if (ctl[2]) mar <= {3'b000, SAVE_A};
         if (ctl[3]) mbr <= mem[mar[7:0]];
         if (ctl[4]) mbr <= {5'b00000, pc};
         if (ctl[5]) mem[mar[7:0]] <= mbr;
         if (ctl[6]) pc <= pc + 11'd1;
         if (ctl[7]) pc <= HDL_A;
         if (ctl[8] || ctl[9]) ir <= ir_nx;
         if (ctl[12]) ac <= r1 + mbr;
         if (ctl[13]) ac <= r1 & mbr;
         if (ctl[14]) r1 <= ac;
      end
   end

   int n_chk  = 0;
   int n_fail = 0;
   int r10_bad = 0;
   bit done = 1'b0;

   always @(negedge clk)
      if (rst_n && ((ctl[10] && ctl[11]) || $countones(ctl[2:0]) > 1 || (ctl[3] && ctl[4])))
         r10_bad++;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step(input int ecar, input logic [14:0] ectl, input string req);
      @(negedge clk);
      chk(car == 5'(ecar), req, "car", int'(car), ecar);
      chk(ctl == ectl, req, "ctl", int'(ctl), int'(ectl));
   endtask

   task automatic after_edge();
      @(posedge clk);
      #2;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk(car == 5'd0, "R1", "car in reset", int'(car), 0);
      chk(ctl == 15'h0, "R1", "ctl in reset", int'(ctl), 0);
      rst_n = 1'b1;
      chk(car == 5'd0, "R1", "car after release", int'(car), 0);
      after_edge();
      chk(car == 5'd0 && ctl == V_F0, "R1", "first word", int'(ctl), int'(V_F0));
   endtask

   task automatic t_add_direct();
      step(0, V_F0, "R2"); step(1, V_F1, "R2"); step(2, V_F2, "R2");
      step(9, V_MARI, "R3_R6"); step(10, V_RD, "R6"); step(11, V_ADD, "R6");
      step(15, V_TAIL, "R6");
      after_edge();
      chk(r1 == 16'd8, "R6", "r1 after add", int'(r1), 8);
      chk(car == 5'd0, "R11", "car back at fetch", int'(car), 0);
   endtask

   task automatic t_and_indirect();
      step(0, V_F0, "R2"); step(1, V_F1, "R2"); step(2, V_F2, "R3");
      step(3, V_MARI, "R4"); step(4, V_RD, "R4"); step(5, V_I2, "R4");
      step(12, V_MARI, "R7"); step(13, V_RD, "R7"); step(14, V_AND, "R7");
      step(15, V_TAIL, "R7");
      after_edge();
      chk(r1 == 16'd0, "R7", "r1 after and", int'(r1), 0);
      chk(ir[10:0] == 11'h030, "R4", "ir address", int'(ir[10:0]), 'h30);
   endtask

   task automatic t_undef();
      step(0, V_F0, "R2"); step(1, V_F1, "R2"); step(2, V_F2, "R5");
      after_edge();
      chk(car == 5'd0 && ctl == V_F0, "R5", "undefined opcode to fetch", int'(car), 0);
      chk(pc == 11'd3, "R5", "pc", int'(pc), 3);
   endtask

   task automatic t_irq_path();
      irq_pend = 1'b1;
      step(0, V_F0, "R8"); step(1, V_F1, "R8"); step(2, V_F2, "R8");
      step(9, V_MARI, "R8"); step(10, V_RD, "R6"); step(11, V_ADD, "R6");
      step(15, V_TAIL, "R8");
      step(6, V_Q0, "R9"); step(7, V_Q1, "R9"); step(8, V_Q2, "R9");
      after_edge();
      chk(car == 5'd0, "R9", "return to fetch with irq high", int'(car), 0);
      chk(mem[SAVE_A] == 16'd4, "R9", "saved pc", int'(mem[SAVE_A]), 4);
      chk(pc == HDL_A, "R9", "pc at handler", int'(pc), int'(HDL_A));
      chk(r1 == 16'd5, "R8", "r1 written before interrupt", int'(r1), 5);
   endtask

   task automatic t_irq_ignored();
      irq_pend = 1'b1;
      step(0, V_F0, "R8"); step(1, V_F1, "R8"); step(2, V_F2, "R8");
      step(12, V_MARI, "R8"); step(13, V_RD, "R7"); step(14, V_AND, "R7");
      irq_pend = 1'b0;
      step(15, V_TAIL, "R8");
      after_edge();
      chk(car == 5'd0 && ctl == V_F0, "R8", "fetch without irq", int'(car), 0);
      chk(r1 == 16'd4, "R7", "r1 after handler and", int'(r1), 4);
   endtask

   initial begin
      t_reset();
      t_add_direct();
      t_and_indirect();
      t_undef();
      t_irq_path();
      t_irq_ignored();
      chk(r10_bad == 0, "R10", "exclusive sources", r10_bad, 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog all requirements actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule